// File: doc/BRIEF.md
# Single-Level Interrupt Entry and Return Unit

This block keeps the interrupt state of a processor with one enable level: an enable flag, a saved program counter and a source-information word. At each instruction boundary the sequencer pulses `fetch_start`. If a request is waiting and interrupts are on, the block takes the interrupt. It saves the current PC and the 16-bit source information, turns interrupts off, and redirects the PC to a vector built from the 8-bit source code. It then pulses an acknowledge back to the requester.

The block also executes five control operations, each picked by opcode when `op_valid` is high: return from interrupt, enable, disable, read the interrupt state out to two register ports, and load that state from two register ports. Priority between several sources and the storage of the general registers are handled outside this block.

Top module: `intr_unit`

## Requirements
- R1: After reset the enable flag, the acknowledge output, the saved PC and the information word are all zero.
- R2: An interrupt is taken only in a cycle where `fetch_start`, `irq_req` and the enable flag are all 1. In any other cycle `pc_load` is raised only by a return operation.
- R3: On entry the saved PC takes `pc_cur` and the information word takes `irq_info`. The upper 16 bits of the 32-bit information value always read as zero.
- R4: On entry `pc_load` is 1 in the same cycle with `pc_next` equal to the vector, and the enable flag is 0 from the next cycle on.
- R5: The vector has bits 31..12 zero, bits 11..4 equal to `irq_code`, and bits 3..0 zero.
- R6: `irq_ack` is 1 for exactly one cycle, in the cycle after the entry.
- R7: Opcode 29 (return) raises `pc_load` with `pc_next` equal to the saved PC, and it sets the enable flag at the same clock edge.
- R8: Opcode 10 sets the enable flag and opcode 11 clears it.
- R9: Opcode 16 raises `rd_en` and drives the zero-extended information word on `rd_info` and the saved PC on `rd_epc`. When opcode 16 is not executing, all three outputs are zero.
- R10: Opcode 17 loads the saved PC from `wr_epc` and the information word from the low 16 bits of `wr_info`. The upper 16 bits of `wr_info` are discarded.
- R11: When no interrupt is taken, any other opcode, or `op_valid` at 0, changes no interrupt state. `pc_next` is zero when `pc_load` is 0.
- R12: If an operation and an entry happen in the same cycle, the entry wins and the operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_start | input | 1 | Instruction boundary strobe |
| irq_req | input | 1 | Interrupt request pending |
| irq_code | input | 8 | Source code used to form the vector |
| irq_info | input | 16 | Source information saved on entry |
| pc_cur | input | 32 | Current program counter |
| op_valid | input | 1 | Operation strobe |
| opcode | input | 5 | Operation code |
| wr_info | input | 32 | Information value for the load operation |
| wr_epc | input | 32 | Saved-PC value for the load operation |
| pc_load | output | 1 | PC redirect request |
| pc_next | output | 32 | PC redirect target |
| irq_ack | output | 1 | Acknowledge pulse |
| irq_en | output | 1 | Enable flag |
| rd_en | output | 1 | Read operation strobe |
| rd_info | output | 32 | Information value, zero-extended |
| rd_epc | output | 32 | Saved PC |

## Verification
The bench builds the block with its default parameters: a 32-bit PC, an 8-bit code at bit 4, a 16-bit information word and a 5-bit opcode. These values make the vector's zero fields and the discarded upper half of the information word directly visible. Random cycles overlap boundaries, requests and operations, so entries collide with return, enable and load operations. Directed cases use the codes 0x00 and 0xFF and write-then-read of the saved state.

// File: rtl/intr_unit.sv
module intr_unit #(
  parameter int PC_W    = 32,
  parameter int CODE_W  = 8,
  parameter int INFO_W  = 16,
  parameter int VEC_LSB = 4,
  parameter int OP_W    = 5,
  parameter int OP_RET  = 29,
  parameter int OP_EN   = 10,
  parameter int OP_DIS  = 11,
  parameter int OP_RD   = 16,
  parameter int OP_WR   = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_start,
  input  logic              irq_req,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [INFO_W-1:0] irq_info,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   opcode,
  input  logic [PC_W-1:0]   wr_info,
  input  logic [PC_W-1:0]   wr_epc,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_next,
  output logic              irq_ack,
  output logic              irq_en,
  output logic              rd_en,
  output logic [PC_W-1:0]   rd_info,
  output logic [PC_W-1:0]   rd_epc
);
  localparam int VEC_MSB = VEC_LSB + CODE_W - 1;

  logic              ien_q, ack_q;
  logic [PC_W-1:0]   epc_q;
  logic [INFO_W-1:0] info_q;
  logic [PC_W-1:0]   vec;
  logic              take, op_act, do_ret, do_en, do_dis, do_rd, do_wr;

  assign take   = fetch_start & irq_req & ien_q;
  assign op_act = op_valid & ~take;
  assign do_ret = op_act & (opcode == OP_W'(OP_RET));
  assign do_en  = op_act & (opcode == OP_W'(OP_EN));
  assign do_dis = op_act & (opcode == OP_W'(OP_DIS));
  assign do_rd  = op_act & (opcode == OP_W'(OP_RD));
  assign do_wr  = op_act & (opcode == OP_W'(OP_WR));

  always_comb begin
    vec = '0;
    vec[VEC_MSB:VEC_LSB] = irq_code;
  end

  assign pc_load = take | do_ret;
  assign pc_next = take ? vec : (do_ret ? epc_q : '0);
  assign irq_ack = ack_q;
  assign irq_en  = ien_q;
  assign rd_en   = do_rd;
  assign rd_info = do_rd ? {{(PC_W-INFO_W){1'b0}}, info_q} : '0;
  assign rd_epc  = do_rd ? epc_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q  <= 1'b0;
      ack_q  <= 1'b0;
      epc_q  <= '0;
      info_q <= '0;
    end else begin
      ack_q <= take;
      if (take) begin
        ien_q  <= 1'b0;
        epc_q  <= pc_cur;
        info_q <= irq_info;
      end else begin
        if (do_ret | do_en) ien_q <= 1'b1;
        if (do_dis)         ien_q <= 1'b0;
        if (do_wr) begin
          epc_q  <= wr_epc;
          info_q <= wr_info[INFO_W-1:0];
        end
      end
    end
  end
endmodule

module intr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        fetch_start,
  input logic        irq_req,
  input logic        op_valid,
  input logic [4:0]  opcode,
  input logic [31:0] pc_cur,
  input logic        pc_load,
  input logic [31:0] pc_next,
  input logic        irq_ack,
  input logic        irq_en,
  input logic [31:0] epc_q
);
  logic take_c;
  assign take_c = fetch_start && irq_req && irq_en;

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
  assert_ack_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    take_c |=> irq_ack);
  assert_entry_disables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_c |=> !irq_en);
  assert_entry_saves_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_c |=> epc_q == $past(pc_cur));
  assert_vector_shape_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_c |-> (pc_load && pc_next[3:0] == 4'h0 && pc_next[31:12] == 20'h0));
  assert_ret_enables_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd29 && !take_c) |=> irq_en);
  assert_disable_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode == 5'd11 && !take_c) |=> !irq_en);
  assert_load_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && !(op_valid && opcode == 5'd29)) |-> take_c);
endmodule

bind intr_unit intr_unit_chk i_chk (
  .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .irq_req(irq_req),
  .op_valid(op_valid), .opcode(opcode), .pc_cur(pc_cur), .pc_load(pc_load),
  .pc_next(pc_next), .irq_ack(irq_ack), .irq_en(irq_en), .epc_q(epc_q)
);

// File: tb/test_intr_unit.sv
module test_intr_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_start = 0, irq_req = 0, op_valid = 0;
  logic [7:0] irq_code = 0;
  logic [15:0] irq_info = 0;
  logic [31:0] pc_cur = 0, wr_info = 0, wr_epc = 0;
  logic [4:0] opcode = 0;
  logic pc_load, irq_ack, irq_en, rd_en;
  logic [31:0] pc_next, rd_info, rd_epc;

  int n_chk = 0, n_fail = 0;
  logic m_ien = 0, m_ack = 0;
  logic [31:0] m_epc = 0;
  logic [15:0] m_info = 0;

  always #2.5 clk = ~clk;

  intr_unit i_intr_unit (
    .clk(clk), .rst_n(rst_n), .fetch_start(fetch_start), .irq_req(irq_req),
    .irq_code(irq_code), .irq_info(irq_info), .pc_cur(pc_cur),
    .op_valid(op_valid), .opcode(opcode), .wr_info(wr_info), .wr_epc(wr_epc),
    .pc_load(pc_load), .pc_next(pc_next), .irq_ack(irq_ack), .irq_en(irq_en),
    .rd_en(rd_en), .rd_info(rd_info), .rd_epc(rd_epc)
  );

  function automatic logic [31:0] vec_of(input logic [7:0] c);
    return {20'h0, c, 4'h0};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic fs, input logic rq, input logic [7:0] code,
                      input logic [15:0] info, input logic [31:0] pc,
                      input logic ov, input logic [4:0] op,
                      input logic [31:0] wi, input logic [31:0] we);
    logic take, act;
    logic [31:0] e_next;
    fetch_start = fs; irq_req = rq; irq_code = code; irq_info = info;
    pc_cur = pc; op_valid = ov; opcode = op; wr_info = wi; wr_epc = we;
    #1;
    take = fs && rq && m_ien;
    act  = ov && !take;
    e_next = take ? vec_of(code) : ((act && op == 5'd29) ? m_epc : 32'h0);
    check(take ? "R4" : "R2", {31'b0, pc_load}, {31'b0, take || (act && op == 5'd29)});
    check(take ? "R5" : "R11", pc_next, e_next);
    check("R9", {31'b0, rd_en}, {31'b0, act && op == 5'd16});
    check("R9", rd_info, (act && op == 5'd16) ? {16'h0, m_info} : 32'h0);
    check("R9", rd_epc, (act && op == 5'd16) ? m_epc : 32'h0);
    @(posedge clk);
    m_ack = take;
    if (take) begin
      m_ien = 0; m_epc = pc; m_info = info;
    end else if (act) begin
      if (op == 5'd29 || op == 5'd10) m_ien = 1;
      if (op == 5'd11) m_ien = 0;
      if (op == 5'd17) begin m_epc = we; m_info = wi[15:0]; end
    end
    @(negedge clk);
    check(take ? "R4" : "R8", {31'b0, irq_en}, {31'b0, m_ien});
    check("R6", {31'b0, irq_ack}, {31'b0, m_ack});
  endtask

  task automatic readback(input string req);
    fetch_start = 0; irq_req = 0; op_valid = 1; opcode = 5'd16;
    #1;
    check(req, rd_epc, m_epc);
    check(req, rd_info, {16'h0, m_info});
    step(0, 0, 0, 0, 0, 1, 5'd16, 0, 0);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s;
    s = $urandom(32'd1234);
    #1;
    // R1 reset state
    check("R1", {31'b0, irq_en}, 32'h0);
    check("R1", {31'b0, irq_ack}, 32'h0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    readback("R1");
    // R2 request while disabled is ignored
    step(1, 1, 8'h55, 16'hAAAA, 32'h100, 0, 0, 0, 0);
    readback("R11");
    // R8 enable then R4/R5 entry with code FF
    step(0, 0, 0, 0, 0, 1, 5'd10, 0, 0);
    step(1, 1, 8'hFF, 16'hBEEF, 32'h1234_5678, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    readback("R3");
    // R7 return
    step(0, 0, 0, 0, 0, 1, 5'd29, 0, 0);
    // R12 entry with code 00 colliding with a load op
    step(1, 1, 8'h00, 16'h0F0F, 32'hCAFE_0000, 1, 5'd17, 32'hFFFF_1111, 32'h2222_2222);
    readback("R12");
    // R10 load discards upper info half
    step(0, 0, 0, 0, 0, 1, 5'd17, 32'hDEAD_5A5A, 32'h8000_0004);
    readback("R10");
    step(0, 0, 0, 0, 0, 1, 5'd11, 0, 0);
    step(0, 0, 0, 0, 0, 1, 5'd3, 32'h1, 32'h1);
    readback("R11");
    for (int i = 0; i < 3000; i++) begin
      logic [4:0] op;
      int r;
      r = $urandom_range(0, 6);
      case (r)
        0: op = 5'd29; 1: op = 5'd10; 2: op = 5'd11;
        3: op = 5'd16; 4: op = 5'd17; default: op = 5'($urandom);
      endcase
      step(1'($urandom), 1'($urandom), 8'($urandom), 16'($urandom), $urandom,
           1'($urandom), op, $urandom, $urandom);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule